// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the synchronous address and control front end of a flow-through burst SRAM. On a rising clock edge at which either address strobe is active, it captures an external word address, the three chip enables and the burst-order pin. One strobe belongs to the processor and one to the cache controller. The captured address goes straight to the array in the next cycle. The two low address bits then step through a four-beat burst under an advance input. The strobe cycle plus that one register stage give the familiar 2-1-1-1 beat pattern: two cycles to the first word, then one per word.

The burst order is either interleaved, where the low bits are the start bits XOR a beat count, or linear, where the start bits plus the beat count wrap modulo four. The upper address bits never change inside a burst. The block also drives a chip-selected flag and a burst-active flag. The burst-active flag stays high until the advance past the fourth beat, which returns the address to the first word of the burst.

Top module: `bsram_addr_seq`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `sel_o` and `burst_o` are 0 and `word_addr_o` is all zeros.
- R2: A load occurs at a clock edge when `cpu_strb_n` is 0 with `ce_pipe_n` 0, or when `ctl_strb_n` is 0. After a load, `word_addr_o` equals the address sampled at that edge, with the beat count at 0.
- R3: At a load, `sel_o` takes the value 1 only if `ce_pipe_n`=0, `ce_exp_hi`=1 and `ce_exp_lo_n`=0, and 0 otherwise. `burst_o` takes the same value. Both hold until the next load.
- R4: A processor strobe while `ce_pipe_n`=1 (controller strobe inactive) is ignored: address, `sel_o` and `burst_o` stay unchanged.
- R5: A controller strobe while `ce_pipe_n`=1 deselects the device: `sel_o`=0 and `burst_o`=0 in the next cycle.
- R6: With no load and `adv_n`=1, `word_addr_o` and `burst_o` hold their values.
- R7: With `order_il`=1 sampled at the load, the low two address bits of beat k (k = 0..3) are the start bits XOR k.
- R8: With `order_il`=0 sampled at the load, the low two address bits of beat k are (start bits + k) mod 4.
- R9: Between loads, the address bits above the low two never change: there is no carry out of the beat count.
- R10: The advance past the fourth beat returns the address to the first burst address and clears `burst_o`. `sel_o` is unaffected. `burst_o` is never 1 while `sel_o` is 0.
- R11: A load wins over an advance in the same cycle, so a new strobe restarts the address at the new start, even in the middle of a burst.
- R12: Both strobes active in the same cycle perform exactly the same load as either strobe alone.
- R13: While `sel_o` is 0, `adv_n`=0 does not move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| ce_pipe_n | input | 1 | Pipelining chip enable, active low |
| ce_exp_hi | input | 1 | Depth-expansion enable, active high |
| ce_exp_lo_n | input | 1 | Depth-expansion enable, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| word_addr_o | output | ADDR_W | Current internal word address |
| sel_o | output | 1 | Device selected |
| burst_o | output | 1 | Burst beats remain |

## Verification
The assertions check on every cycle that a load captures the sampled address and the combined enables. They also check that a controller strobe with the pipelining enable off deselects the device, and that an ignored processor strobe changes nothing. Further cycle-by-cycle checks cover address hold without advance, the upper bits staying put between loads, a deselected device holding its address, and the burst flag clearing after the wrap. Only the bench's sweeps can show that the beat-by-beat low bits follow the interleaved and linear orders for every start value. The same holds for the wrap back to the first word, for dual-strobe loads, and for a strobe pre-empting a burst in progress.

// File: rtl/bsram_seq_pkg.sv
package bsram_seq_pkg;
  // Width of the in-burst beat counter (four beats)
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits of a beat: XOR order or wrapping add
  function automatic beat_t beat_lo(beat_t start, beat_t cnt, logic il);
    beat_t r;
    if (il) r = start ^ cnt;
    else    r = start + cnt;
    return r;
  endfunction

  // All three chip enables in their active state
  function automatic logic enables_on(logic pipe_n, logic exp_hi, logic exp_lo_n);
    return !pipe_n && exp_hi && !exp_lo_n;
  endfunction
endpackage

// File: rtl/bsram_sel_dec.sv
module bsram_sel_dec
  import bsram_seq_pkg::*;
(
  input  logic cpu_strb_n,
  input  logic ctl_strb_n,
  input  logic ce_pipe_n,
  input  logic ce_exp_hi,
  input  logic ce_exp_lo_n,
  output logic load_ev,
  output logic sel_next,
  output logic cpu_ign_ev
);
  logic cpu_go, ctl_go;

  // Processor strobe only counts with the pipelining enable on
  assign cpu_go     = !cpu_strb_n && !ce_pipe_n;
  assign ctl_go     = !ctl_strb_n;
  assign load_ev    = cpu_go || ctl_go;
  assign cpu_ign_ev = !cpu_strb_n && ce_pipe_n && !ctl_go;
  assign sel_next   = enables_on(ce_pipe_n, ce_exp_hi, ce_exp_lo_n);
endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
  import bsram_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_ev,
  input  logic  sel_next,
  input  logic  adv_n,
  output beat_t cnt,
  output logic  sel_q,
  output logic  burst_q,
  output logic  adv_ev,
  output logic  wrap_ev
);
  localparam beat_t LAST = '1;

  // A load always wins over an advance
  assign adv_ev  = !load_ev && !adv_n && sel_q;
  assign wrap_ev = adv_ev && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_q   <= 1'b0;
      burst_q <= 1'b0;
    end else if (load_ev) begin
      cnt     <= '0;
      sel_q   <= sel_next;
      burst_q <= sel_next;
    end else if (adv_ev) begin
      cnt <= cnt + beat_t'(1);
      if (wrap_ev) burst_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bsram_addr_reg.sv
module bsram_addr_reg
  import bsram_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_il,
  input  beat_t             cnt,
  output logic [ADDR_W-1:0] word_addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0] up_q;
  beat_t           start_q;
  logic            il_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= '0;
      start_q <= '0;
      il_q    <= 1'b0;
    end else if (load_ev) begin
      up_q    <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
      il_q    <= order_il;
    end
  end

  // Upper bits pass through untouched: no carry out of the beat
  assign word_addr_o = {up_q, beat_lo(start_q, cnt, il_q)};
endmodule

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq
  import bsram_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_pipe_n,
  input  logic              ce_exp_hi,
  input  logic              ce_exp_lo_n,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              sel_o,
  output logic              burst_o
);
  // Named internal events, used by the bound checker
  logic  load_ev, sel_next, cpu_ign_ev, adv_ev, wrap_ev;
  beat_t cnt;

  bsram_sel_dec u_dec (
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .ce_pipe_n  (ce_pipe_n),
    .ce_exp_hi  (ce_exp_hi),
    .ce_exp_lo_n(ce_exp_lo_n),
    .load_ev    (load_ev),
    .sel_next   (sel_next),
    .cpu_ign_ev (cpu_ign_ev)
  );

  bsram_burst_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .sel_next(sel_next),
    .adv_n   (adv_n),
    .cnt     (cnt),
    .sel_q   (sel_o),
    .burst_q (burst_o),
    .adv_ev  (adv_ev),
    .wrap_ev (wrap_ev)
  );

  bsram_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .addr_i     (addr_i),
    .order_il   (order_il),
    .cnt        (cnt),
    .word_addr_o(word_addr_o)
  );
endmodule

// File: rtl/bsram_addr_seq_chk.sv
module bsram_addr_seq_chk
  import bsram_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_pipe_n,
  input logic              ce_exp_hi,
  input logic              ce_exp_lo_n,
  input logic              ctl_strb_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] word_addr_o,
  input logic              sel_o,
  input logic              burst_o,
  input logic              load_ev,
  input logic              cpu_ign_ev,
  input logic              wrap_ev
);
  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (word_addr_o == $past(addr_i)));

  // R3
  load_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (sel_o == $past(!ce_pipe_n && ce_exp_hi && !ce_exp_lo_n)));

  // R4
  cpu_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ign_ev && adv_n) |=> ($stable(word_addr_o) && $stable(sel_o) && $stable(burst_o)));

  // R5
  ctl_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strb_n && ce_pipe_n) |=> (!sel_o && !burst_o));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && adv_n) |=> ($stable(word_addr_o) && $stable(burst_o)));

  // R9
  upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(word_addr_o[ADDR_W-1:BEAT_W]));

  // R10
  wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> !burst_o);

  // R10
  burst_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_o |-> sel_o);

  // R13
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !sel_o) |=> $stable(word_addr_o));
endmodule

bind bsram_addr_seq bsram_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .ce_pipe_n  (ce_pipe_n),
  .ce_exp_hi  (ce_exp_hi),
  .ce_exp_lo_n(ce_exp_lo_n),
  .ctl_strb_n (ctl_strb_n),
  .adv_n      (adv_n),
  .word_addr_o(word_addr_o),
  .sel_o      (sel_o),
  .burst_o    (burst_o),
  .load_ev    (load_ev),
  .cpu_ign_ev (cpu_ign_ev),
  .wrap_ev    (wrap_ev)
);

// File: tb/bsram_addr_seq_tb.sv
module bsram_addr_seq_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ce_pipe_n = 1'b0, ce_exp_hi = 1'b1, ce_exp_lo_n = 1'b0;
  logic          cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, adv_n = 1'b1, order_il = 1'b0;
  logic [AW-1:0] word_addr_o;
  logic          sel_o, burst_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bsram_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .ce_pipe_n(ce_pipe_n), .ce_exp_hi(ce_exp_hi), .ce_exp_lo_n(ce_exp_lo_n),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .order_il(order_il), .word_addr_o(word_addr_o), .sel_o(sel_o), .burst_o(burst_o)
  );

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected low bits: interleave as bitwise difference, linear as modular sum
  function automatic logic [1:0] want_lo(int s, int k, bit il);
    int v;
    if (il) v = (s % 4) ^ (k % 4);
    else    v = (s + k) % 4;
    return v[1:0];
  endfunction

  task automatic strobe(logic [AW-1:0] a, bit cpu, bit ctl, bit pn, bit hi, bit ln, bit il);
    addr_i = a; cpu_strb_n = !cpu; ctl_strb_n = !ctl;
    ce_pipe_n = pn; ce_exp_hi = hi; ce_exp_lo_n = ln; order_il = il;
    step();
    cpu_strb_n = 1'b1; ctl_strb_n = 1'b1;
  endtask

  task automatic advance();
    adv_n = 1'b0; step(); adv_n = 1'b1;
  endtask

  task automatic run_burst(logic [AW-3:0] up, int s, bit il, int kind);
    logic [AW-1:0] a;
    string ord;
    a = {up, 2'(s)};
    ord = il ? "R7" : "R8";
    strobe(a, kind != 1, kind != 0, 1'b0, 1'b1, 1'b0, il);
    chk(kind == 2 ? "R12 load addr" : "R2 load addr", word_addr_o, a);
    chk("R3 selected", AW'(sel_o), AW'(1));
    chk("R10 burst set", AW'(burst_o), AW'(1));
    for (int k = 1; k < 4; k++) begin
      advance();
      chk(ord, word_addr_o, {up, want_lo(s, k, il)});
      if (k == 2) begin
        step();
        chk("R6 hold", word_addr_o, {up, want_lo(s, k, il)});
        chk("R6 burst hold", AW'(burst_o), AW'(1));
      end
    end
    advance();
    chk("R10 wrap to first / R9 upper", word_addr_o, a);
    chk("R10 burst cleared", AW'(burst_o), AW'(0));
    chk("R10 still selected", AW'(sel_o), AW'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    // R1 reset state
    step(); step();
    chk("R1 addr", word_addr_o, '0);
    chk("R1 sel", AW'(sel_o), AW'(0));
    chk("R1 burst", AW'(burst_o), AW'(0));
    rst_n = 1'b1;
    step();

    // Sweep: order x start bits x strobe kind
    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 4; s++)
        for (int kind = 0; kind < 3; kind++)
          run_burst((s % 2 == 1) ? '1 : (AW-2)'('h1A3C5 + kind), s, bit'(il), kind);

    // R11: new strobe with advance in the same cycle, mid burst
    strobe({16'h1234, 2'd1}, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    advance();
    adv_n = 1'b0;
    strobe({16'h4321, 2'd2}, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    adv_n = 1'b1;
    chk("R11 restart addr", word_addr_o, {16'h4321, 2'd2});
    chk("R11 burst", AW'(burst_o), AW'(1));

    // R4: processor strobe with pipelining enable off is ignored
    advance();
    strobe({16'hBEEF, 2'd0}, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R4 addr unchanged", word_addr_o, {16'h4321, 2'd3});
    chk("R4 sel unchanged", AW'(sel_o), AW'(1));
    chk("R4 burst unchanged", AW'(burst_o), AW'(1));

    // R5: controller strobe with pipelining enable off deselects
    strobe({16'hCAFE, 2'd1}, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5 sel", AW'(sel_o), AW'(0));
    chk("R5 burst", AW'(burst_o), AW'(0));
    chk("R2 addr on deselecting load", word_addr_o, {16'hCAFE, 2'd1});

    // R13: no advance while deselected
    advance(); advance();
    chk("R13 addr held", word_addr_o, {16'hCAFE, 2'd1});

    // R3: every enable combination via the controller strobe
    for (int e = 0; e < 8; e++) begin
      strobe(AW'(e * 5 + 64), 1'b0, 1'b1, e[0], e[1], e[2], 1'b0);
      chk("R3 enable combo sel", AW'(sel_o), AW'(e == 2));
      chk("R3 enable combo burst", AW'(burst_o), AW'(e == 2));
    end
    // R3: processor strobe with a depth enable off
    strobe({16'h0F0F, 2'd3}, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 cpu partial enables", AW'(sel_o), AW'(0));

    // R1: asynchronous reset in the middle of a burst
    strobe({16'h7777, 2'd2}, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    advance();
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async addr", word_addr_o, '0);
    chk("R1 async sel", AW'(sel_o), AW'(0));
    chk("R1 async burst", AW'(burst_o), AW'(0));

    report();
    $finish;
  end
endmodule